// File: doc/BRIEF.md
# Numerically Controlled Waveform Synthesizer Core

This core produces a periodic waveform from a single 28-bit phase accumulator. On every clock cycle the accumulator advances by one of two frequency tuning words, so the output frequency is the tuning word times the clock rate divided by 2^28. With a 25 MHz clock, one hertz corresponds to a tuning step of about 10.737. One of two 12-bit phase offsets is added to the upper accumulator bits. The resulting 12-bit phase drives a sine converter (a folded quarter-wave table), a triangle converter or a square generator. Two select pins switch between the frequency words and between the offsets, which gives frequency-shift and phase-shift keying without reloading any value.

All configuration inputs are plain levels taken directly from a register interface. Nothing is handshaked: the core emits one output code per clock, so there is no stream and no back-pressure. A clear input parks the output at mid-scale and restarts the waveform from phase zero. A hold input freezes the phase and the outputs. In square modes the parallel converter code can be blanked while the 1-bit square output keeps running.

Top module: `wg_core`

## Requirements
- R1: On each clock edge where neither `gen_clear` nor `gen_hold` is high, the internal 28-bit accumulator A becomes (A + selected tuning word) mod 2^28. The registered outputs at that edge reflect A as it was before the edge, so the outputs lag the accumulator by one cycle.
- R2: `freq_pick` = 0 selects `freq_a` and `freq_pick` = 1 selects `freq_b`. A change to the selected word takes effect at the next clock edge.
- R3: The phase P is A[27:16] plus the selected offset, mod 4096. `ofs_pick` = 0 selects `ofs_a` and `ofs_pick` = 1 selects `ofs_b`.
- R4: Sine mode (`sq_enable` = 0, `tri_sel` = 0) works as follows. Let k = P[9:4], replaced by 63 − k when P[10] = 1, and let q = round(511·sin((k + 0.5)·π/128)). The output `wave_code` is 512 + q when P[11] = 0 and 511 − q when P[11] = 1. `sq_out` is 0.
- R5: Triangle mode (`sq_enable` = 0, `tri_sel` = 1) gives `wave_code` = P[10:1] when P[11] = 0 and the bitwise inverse of P[10:1] when P[11] = 1. `sq_out` is 0.
- R6: Full-rate square mode (`sq_enable` = 1, `sq_full_rate` = 1, `tri_sel` ignored) gives `sq_out` = P[11], and `wave_code` is 1023 when `sq_out` is 1 and 0 otherwise.
- R7: Half-rate square mode (`sq_enable` = 1, `sq_full_rate` = 0) uses a toggle bit that flips whenever P[11] is 1 and was 0 at the previous non-hold edge. The previous value counts as 0 right after a clear. `sq_out` shows the updated toggle bit, and `wave_code` follows it as in R6.
- R8: While `rst_n` is low or `gen_clear` is high, the accumulator, the toggle history and `sq_out` are 0, and `wave_code` is 512. The first output after release is computed from A = 0.
- R9: While `gen_hold` is high (and `gen_clear` is low), the accumulator and toggle history do not change, and `wave_code` and `sq_out` hold their values even if offsets, selects or mode change.
- R10: In either square mode, `conv_off` = 1 forces `wave_code` to 0 without affecting `sq_out`. In sine and triangle modes `conv_off` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_clear | input | 1 | Clear accumulator, park output at mid-scale |
| gen_hold | input | 1 | Freeze phase and outputs |
| freq_a | input | 28 | Tuning word 0 |
| freq_b | input | 28 | Tuning word 1 |
| freq_pick | input | 1 | Tuning word select |
| ofs_a | input | 12 | Phase offset 0 |
| ofs_b | input | 12 | Phase offset 1 |
| ofs_pick | input | 1 | Phase offset select |
| tri_sel | input | 1 | Triangle instead of sine |
| sq_enable | input | 1 | Square modes |
| sq_full_rate | input | 1 | Square at full rather than half rate |
| conv_off | input | 1 | Blank converter code in square modes |
| wave_code | output | 10 | Unsigned converter code |
| sq_out | output | 1 | Logic square output |

## Verification
On every cycle, the assertions check that a clear parks the outputs and zeroes the accumulator, and that a hold freezes accumulator and outputs. They also check that square modes give only the two full-scale codes (or zero when blanked), that sine and triangle keep `sq_out` low, and that the half-rate toggle changes only on a rising phase MSB. The exact sine and triangle codes, the effect of switching tuning words and offsets, wrap-around of the accumulator and the half-rate period can only be shown by the bench. It compares every output cycle against a reference model computed from the requirement formulas.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE    = 2'd0,
    WAVE_TRI     = 2'd1,
    WAVE_SQ_FULL = 2'd2,
    WAVE_SQ_HALF = 2'd3
  } wave_e;

  // Square enable wins over the triangle bit.
  function automatic wave_e decode_mode(input logic tri_bit, input logic sq_bit,
                                        input logic full_bit);
    if (sq_bit) return full_bit ? WAVE_SQ_FULL : WAVE_SQ_HALF;
    if (tri_bit) return WAVE_TRI;
    return WAVE_SINE;
  endfunction

  // One quarter-wave sample, sampled at the bin centre so that folding is symmetric.
  function automatic int quarter_sine(input int idx, input int depth, input int amp);
    real x;
    x = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(depth));
    return $rtoi(real'(amp) * $sin(x) + 0.5);
  endfunction

endpackage

// File: rtl/wg_phase_acc.sv
module wg_phase_acc #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [ACC_W-1:0] step,
  input  logic [PH_W-1:0]  ofs,
  output logic [PH_W-1:0]  phase
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (!hold) acc_q <= acc_q + step;
  end

  assign phase = acc_q[ACC_W-1 -: PH_W] + ofs;

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(acc_q));

endmodule

// File: rtl/wg_sine_lut.sv
module wg_sine_lut import wg_pkg::*; #(
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 6
) (
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] code
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int QW    = OUT_W - 1;
  localparam int AMP   = (1 << QW) - 1;
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  logic [QW-1:0]     rom [DEPTH];
  logic [LUT_AW-1:0] raw_idx, idx;
  logic [QW-1:0]     q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int VAL = quarter_sine(i, DEPTH, AMP);
    assign rom[i] = QW'(VAL);
  end

  if (PH_W - 2 > LUT_AW) begin : g_low
    logic unused_low;
    assign unused_low = ^phase[PH_W-3-LUT_AW:0];
  end

  assign raw_idx = phase[PH_W-3 -: LUT_AW];
  assign idx     = phase[PH_W-2] ? ~raw_idx : raw_idx;
  assign q       = rom[idx];
  assign code    = phase[PH_W-1] ? (MID - OUT_W'(1) - {1'b0, q}) : (MID + {1'b0, q});

endmodule

// File: rtl/wg_shaper.sv
module wg_shaper import wg_pkg::*; #(
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  wave_e            mode,
  input  logic             conv_off,
  input  logic [PH_W-1:0]  phase,
  input  logic [OUT_W-1:0] sine_code,
  output logic [OUT_W-1:0] wave_code,
  output logic             sq_out
);
  localparam logic [OUT_W-1:0] MID = {1'b1, {(OUT_W-1){1'b0}}};

  logic             msb, msb_q, half_q, half_n, rise;
  logic [OUT_W-1:0] tri_code, code_n;
  logic             sq_n;

  if (PH_W - 1 > OUT_W) begin : g_low
    logic unused_low;
    assign unused_low = ^phase[PH_W-2-OUT_W:0];
  end

  assign msb      = phase[PH_W-1];
  assign rise     = msb & ~msb_q;
  assign half_n   = half_q ^ rise;
  assign tri_code = msb ? ~phase[PH_W-2 -: OUT_W] : phase[PH_W-2 -: OUT_W];

  always_comb begin
    code_n = sine_code;
    sq_n   = 1'b0;
    case (mode)
      WAVE_SINE:    code_n = sine_code;
      WAVE_TRI:     code_n = tri_code;
      WAVE_SQ_FULL: begin
        sq_n   = msb;
        code_n = conv_off ? '0 : {OUT_W{msb}};
      end
      WAVE_SQ_HALF: begin
        sq_n   = half_n;
        code_n = conv_off ? '0 : {OUT_W{half_n}};
      end
      default: code_n = sine_code;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0; half_q <= 1'b0; sq_out <= 1'b0; wave_code <= MID;
    end else if (clr) begin
      msb_q <= 1'b0; half_q <= 1'b0; sq_out <= 1'b0; wave_code <= MID;
    end else if (!hold) begin
      msb_q     <= msb;
      half_q    <= half_n;
      sq_out    <= sq_n;
      wave_code <= code_n;
    end
  end

  p_clear_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wave_code == MID && !sq_out));

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> ($stable(wave_code) && $stable(sq_out)));

  p_no_square_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold && (mode == WAVE_SINE || mode == WAVE_TRI)) |=> !sq_out);

  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold && conv_off && (mode == WAVE_SQ_FULL || mode == WAVE_SQ_HALF))
    |=> (wave_code == '0));

  p_toggle_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold && !(msb && !msb_q)) |=> $stable(half_q));

endmodule

// File: rtl/wg_core.sv
module wg_core import wg_pkg::*; #(
  parameter int ACC_W  = 28,
  parameter int PH_W   = 12,
  parameter int OUT_W  = 10,
  parameter int LUT_AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_clear,
  input  logic             gen_hold,
  input  logic [ACC_W-1:0] freq_a,
  input  logic [ACC_W-1:0] freq_b,
  input  logic             freq_pick,
  input  logic [PH_W-1:0]  ofs_a,
  input  logic [PH_W-1:0]  ofs_b,
  input  logic             ofs_pick,
  input  logic             tri_sel,
  input  logic             sq_enable,
  input  logic             sq_full_rate,
  input  logic             conv_off,
  output logic [OUT_W-1:0] wave_code,
  output logic             sq_out
);
  logic [ACC_W-1:0] step;
  logic [PH_W-1:0]  ofs, phase;
  logic [OUT_W-1:0] sine_code;
  wave_e            mode;

  assign step = freq_pick ? freq_b : freq_a;
  assign ofs  = ofs_pick ? ofs_b : ofs_a;
  assign mode = decode_mode(tri_sel, sq_enable, sq_full_rate);

  wg_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(gen_clear), .hold(gen_hold),
    .step(step), .ofs(ofs), .phase(phase)
  );

  wg_sine_lut #(.PH_W(PH_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) u_sine (
    .phase(phase), .code(sine_code)
  );

  wg_shaper #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .clr(gen_clear), .hold(gen_hold),
    .mode(mode), .conv_off(conv_off), .phase(phase), .sine_code(sine_code),
    .wave_code(wave_code), .sq_out(sq_out)
  );

  p_square_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_clear && !gen_hold && sq_enable && !conv_off)
    |=> (wave_code == {OUT_W{sq_out}}));

endmodule

// File: tb/wg_core_test.sv
`timescale 1ns/1ps
module wg_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_clear = 1'b1, gen_hold = 1'b0;
  logic [27:0] freq_a = '0, freq_b = '0;
  logic        freq_pick = 1'b0;
  logic [11:0] ofs_a = '0, ofs_b = '0;
  logic        ofs_pick = 1'b0, tri_sel = 1'b0, sq_enable = 1'b0;
  logic        sq_full_rate = 1'b0, conv_off = 1'b0;
  logic [9:0]  wave_code;
  logic        sq_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [27:0] acc_m = '0;
  logic        msbq_m = 1'b0, half_m = 1'b0, sq_m = 1'b0;
  logic [9:0]  wave_m = 10'd512;

  always #2 clk = ~clk;

  wg_core uut (
    .clk(clk), .rst_n(rst_n), .gen_clear(gen_clear), .gen_hold(gen_hold),
    .freq_a(freq_a), .freq_b(freq_b), .freq_pick(freq_pick),
    .ofs_a(ofs_a), .ofs_b(ofs_b), .ofs_pick(ofs_pick),
    .tri_sel(tri_sel), .sq_enable(sq_enable), .sq_full_rate(sq_full_rate),
    .conv_off(conv_off), .wave_code(wave_code), .sq_out(sq_out)
  );

  // R4 reference
  function automatic logic [9:0] sine_ref(input logic [11:0] p);
    int  k, q;
    real x;
    k = int'(p[9:4]);
    if (p[10]) k = 63 - k;
    x = (real'(k) + 0.5) * 3.14159265358979 / 128.0;
    q = $rtoi(511.0 * $sin(x) + 0.5);
    return p[11] ? 10'(511 - q) : 10'(512 + q);
  endfunction

  // R5 reference
  function automatic logic [9:0] tri_ref(input logic [11:0] p);
    return p[11] ? ~p[10:1] : p[10:1];
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (wave_code !== wave_m || sq_out !== sq_m) begin
      fails++;
      $display("FAIL %s: actual wave=%0d sq=%0b expected wave=%0d sq=%0b",
               tag, wave_code, sq_out, wave_m, sq_m);
    end
  endtask

  task automatic tick(input string tag);
    logic [11:0] s;
    logic m, hn, q;
    logic [9:0] w;
    @(posedge clk);
    if (!rst_n || gen_clear) begin
      acc_m = '0; msbq_m = 0; half_m = 0; sq_m = 0; wave_m = 10'd512;
    end else if (!gen_hold) begin
      s  = acc_m[27:16] + (ofs_pick ? ofs_b : ofs_a);
      m  = s[11];
      hn = half_m ^ (m & ~msbq_m);
      if (sq_enable) begin
        q = sq_full_rate ? m : hn;
        w = conv_off ? 10'd0 : {10{q}};
      end else begin
        q = 1'b0;
        w = tri_sel ? tri_ref(s) : sine_ref(s);
      end
      wave_m = w; sq_m = q; msbq_m = m; half_m = hn;
      acc_m  = acc_m + (freq_pick ? freq_b : freq_a);
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R8 reset state
    repeat (3) @(negedge clk);
    compare("R8 reset");
    rst_n = 1'b1;
    run(2, "R8 clear held");

    // R8 release starts from phase zero; R1/R4 sine stepping
    freq_a = 28'h100_0000;
    @(negedge clk) gen_clear = 1'b0;
    tick("R8 first sample");
    checks++;
    if (wave_code !== sine_ref(12'h000)) begin
      fails++;
      $display("FAIL R8 phase zero: actual %0d expected %0d", wave_code, sine_ref(12'h000));
    end
    run(40, "R1 R4 sine");

    // R1 wrap with the largest tuning word
    freq_a = 28'hFFF_FFFF;
    run(20, "R1 wrap");

    // R5 triangle
    tri_sel = 1'b1; freq_a = 28'h03A_5C31;
    run(60, "R5 triangle");

    // R2 frequency switching and live update of the active word
    tri_sel = 1'b0; freq_a = 28'h040_0000; freq_b = 28'h0C0_0000;
    for (int i = 0; i < 8; i++) begin
      freq_pick = ~freq_pick;
      run(5, "R2 fsk");
    end
    freq_b = 28'h011_1111;
    run(6, "R2 live write");

    // R3 phase switching, offset at its edge value
    ofs_a = 12'h000; ofs_b = 12'hFFF;
    for (int i = 0; i < 8; i++) begin
      ofs_pick = ~ofs_pick;
      run(4, "R3 psk");
    end
    ofs_b = 12'h800; run(6, "R3 half-turn");

    // R6 full-rate square, triangle bit ignored
    ofs_pick = 1'b0; freq_pick = 1'b0; freq_a = 28'h200_0000;
    sq_enable = 1'b1; sq_full_rate = 1'b1; tri_sel = 1'b1;
    run(40, "R6 square full");

    // R7 half-rate square
    sq_full_rate = 1'b0;
    run(64, "R7 square half");

    // R10 blanking in square, ignored in sine and triangle
    conv_off = 1'b1; run(20, "R10 blank square");
    sq_enable = 1'b0; run(20, "R10 ignored tri");
    tri_sel = 1'b0; run(20, "R10 ignored sine");
    conv_off = 1'b0;

    // R9 hold with select and mode changes underneath
    gen_hold = 1'b1;
    run(3, "R9 hold");
    ofs_pick = 1'b1; run(3, "R9 hold ofs change");
    sq_enable = 1'b1; sq_full_rate = 1'b1; run(3, "R9 hold mode change");
    freq_pick = 1'b1; run(3, "R9 hold freq change");
    gen_hold = 1'b0; run(10, "R9 resume");

    // R8 clear mid-run in square mode, then restart
    gen_clear = 1'b1; run(3, "R8 clear");
    gen_clear = 1'b0; run(20, "R8 restart");

    // Random mix
    for (int seg = 0; seg < 120; seg++) begin
      freq_a = 28'($urandom_range(32'h0FFF_FFFF, 0));
      freq_b = 28'($urandom_range(32'h03FF_FFFF, 32'h0001_0000));
      ofs_a = 12'($urandom); ofs_b = 12'($urandom);
      tri_sel = 1'($urandom); sq_enable = 1'($urandom);
      sq_full_rate = 1'($urandom); conv_off = 1'($urandom);
      for (int c = 0; c < 16; c++) begin
        freq_pick = 1'($urandom); ofs_pick = 1'($urandom);
        gen_hold  = ($urandom_range(9, 0) == 0);
        gen_clear = ($urandom_range(19, 0) == 0);
        tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule